// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot control and slot status registers of a hot-plug capable downstream port. Software programs the control register (indicator states, event enables, the master hot-plug interrupt enable and an interlock command bit) through a 16-bit write port with two byte enables. It clears event flags in the status register by writing ones. Hardware-side inputs report attention button presses and requests to add or remove the device in the slot. A request is refused with a busy response while the electromechanical interlock is engaged.

Each write to the control register counts as one command, and that command completes in the cycle of the write. The block combines the status flags, their enables and the master enable into one pending condition. It signals only when that condition changes. In message mode (MSI-X or MSI enabled) it raises a one-cycle message request that carries the vector number. Otherwise it drives a level interrupt line to follow the condition.

Top module: `slot_hotplug_ctl`

## Requirements
- R1: After reset the control register reads 0x03C0: both indicator fields (bits 7:6 attention, bits 9:8 power) hold 2'b11 (Off), and every enable and the interlock command bit are 0. Status bits 0, 3, 4 (button, presence changed, command done) and bit 7 (interlock engaged) read 0. Neither interrupt output is active.
- R2: Status bit 6 (device present) takes the value of `presentAtReset` during reset, and no event flag is set as a result.
- R3: Control write: a byte is written only when its enable is high. The writable bits are 0 (button enable), 3 (presence-change enable), 4 (command-done enable), 5 (master interrupt enable), 7:6, 9:8 and 11. Bits 1, 2, 10 and 15:12 always read 0.
- R4: A control write with at least one byte enable set sets status bit 4 (command done) at the next clock edge. A write with both enables low does nothing.
- R5: Control bit 11 always reads 0. Writing it as 1 (high byte enabled) toggles status bit 7.
- R6: While status bit 7 is 1, an add or remove request makes `reqBusy` high in the same cycle and changes no register.
- R7: An accepted add request sets status bit 6. An accepted remove request clears it. Either one sets status bit 3.
- R8: `buttonPress` sets status bit 0. Status bits 0, 3 and 4 clear when written with 1 (low byte enabled). Writes to status bits 6 and 7 are ignored.
- R9: The pending condition is true when control bit 5 is 1 and some bit among 0, 3, 4 is 1 in both the status and control registers.
- R10: When `msixEnable` or `msiEnable` is high, every change of the pending condition (rise or fall) gives `msgReq` high for one cycle with `msgVec` = `vecNum`. This does not apply to a fall caused by a status write. Posting an event flag that is already 1 gives no message.
- R11: When both message enables are low, `intxOut` follows the pending condition. A status write deasserts it when nothing is pending. A fall caused by a status write in message mode sends no message.
- R12: An event posted while the master enable is 0 is delivered (message or INTx) when a later control write sets the master enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| presentAtReset | input | 1 | Device present at power-up; sampled during reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 1 | Write target: 0 control, 1 status |
| wrBe | input | 2 | Byte enables of the write |
| wrData | input | 16 | Write data |
| rdSel | input | 1 | Read select: 0 control, 1 status |
| rdData | output | 16 | Read data (combinational) |
| addReq | input | 1 | Device add request |
| removeReq | input | 1 | Device remove request |
| reqBusy | output | 1 | Request refused, interlock engaged |
| buttonPress | input | 1 | Attention button pressed |
| msixEnable | input | 1 | MSI-X delivery enabled |
| msiEnable | input | 1 | MSI delivery enabled |
| vecNum | input | 5 | Interrupt message number |
| msgReq | output | 1 | One-cycle message request |
| msgVec | output | 5 | Vector carried with msgReq |
| intxOut | output | 1 | Level interrupt |

## Verification
The hardest case to reach is one where the pending condition moves without any new event: a fall caused by a control write, which must send a message, against a fall caused by a status write, which must stay silent. The bench reaches the first by clearing the master enable while the command-done flag is still set. It reaches the second by clearing a flag by write-1 while it is the only reason for pending. A second hard case is an event latched while the master enable is off. The bench presses the button with the enable off and delivers the event later through a control write.

// File: rtl/slot_hp_pkg.sv
package slot_hp_pkg;
  localparam int REG_W = 16;
  localparam int VEC_W = 5;

  localparam int B_ABP   = 0;
  localparam int B_PDC   = 3;
  localparam int B_CC    = 4;
  localparam int B_HPIE  = 5;
  localparam int B_PRES  = 6;
  localparam int B_ILOCK = 7;
  localparam int B_ILCMD = 11;

  localparam logic [REG_W-1:0] EVT_MASK   = REG_W'((1 << B_ABP) | (1 << B_PDC) | (1 << B_CC));
  localparam logic [REG_W-1:0] CTL_STORE  = REG_W'(16'h03F9);
  localparam logic [REG_W-1:0] CTL_RESET  = REG_W'(16'h03C0);

  typedef struct packed {
    logic             ctlWr;
    logic [REG_W-1:0] ctlBitEn;
    logic [REG_W-1:0] ctlData;
    logic [REG_W-1:0] stsClr;
    logic             ilockToggle;
    logic             postAbp;
    logic             postPdc;
    logic             presSet;
    logic             presClr;
  } strobe_t;
endpackage

// File: rtl/slot_hp_ctrl.sv
module slot_hp_ctrl
  import slot_hp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [1:0]       wrBe,
  input  logic [REG_W-1:0] wrData,
  input  logic             addReq,
  input  logic             removeReq,
  input  logic             buttonPress,
  input  logic             ilockState,
  input  logic             pendNext,
  input  logic             evtRise,
  input  logic             msixEnable,
  input  logic             msiEnable,
  input  logic [VEC_W-1:0] vecNum,
  output strobe_t          stb,
  output logic             reqBusy,
  output logic             msgReq,
  output logic [VEC_W-1:0] msgVec,
  output logic             intxOut
);
  localparam int BYTE_W = REG_W / 2;

  logic [REG_W-1:0] byteMask;
  logic ctlTouch, stsTouch, anyReq, msgMode, chg, quietDrop, pendQ;

  assign byteMask = {{BYTE_W{wrBe[1]}}, {BYTE_W{wrBe[0]}}};
  assign ctlTouch = wrEn & ~wrSel & (|wrBe);
  assign stsTouch = wrEn &  wrSel & (|wrBe);
  assign anyReq   = addReq | removeReq;
  assign reqBusy  = anyReq & ilockState;

  always_comb begin
    stb             = '0;
    stb.ctlWr       = ctlTouch;
    stb.ctlBitEn    = byteMask & CTL_STORE;
    stb.ctlData     = wrData;
    stb.stsClr      = stsTouch ? (wrData & byteMask & EVT_MASK) : '0;
    stb.ilockToggle = ctlTouch & byteMask[B_ILCMD] & wrData[B_ILCMD];
    stb.postAbp     = buttonPress;
    stb.postPdc     = anyReq & ~ilockState;
    stb.presClr     = removeReq & ~ilockState;
    stb.presSet     = addReq & ~removeReq & ~ilockState;
  end

  assign msgMode   = msixEnable | msiEnable;
  assign chg       = pendNext != pendQ;
  assign quietDrop = stsTouch & ~evtRise;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ   <= 1'b0;
      msgReq  <= 1'b0;
      msgVec  <= '0;
      intxOut <= 1'b0;
    end else begin
      pendQ  <= pendNext;
      msgReq <= msgMode & chg & ~quietDrop;
      if (msgMode && chg && !quietDrop) msgVec <= vecNum;
      if (!msgMode && (chg || (stsTouch && !pendNext))) intxOut <= pendNext;
    end
  end

  // R10: no message unless the pending state moved
  p_quiet_when_steady_r10: assert property (@(posedge clk) disable iff (!rstN)
    $stable(pendQ) |-> !msgReq);

  // R11: in INTx mode the line matches the pending state after every update
  p_intx_tracks_r11: assert property (@(posedge clk) disable iff (!rstN)
    (!msixEnable && !msiEnable && $past(!msixEnable && !msiEnable) && $past(rstN)) |-> (intxOut == pendQ));
endmodule

// File: rtl/slot_hp_regs.sv
module slot_hp_regs
  import slot_hp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             presentAtReset,
  input  strobe_t          stb,
  input  logic             rdSel,
  output logic [REG_W-1:0] rdData,
  output logic             ilockState,
  output logic             pendNext,
  output logic             evtRise
);
  logic [REG_W-1:0] ctlQ, ctlNext, evtQ, evtNext, posted, stsView;
  logic presQ, presNext, ilockQ, ilockNext;

  always_comb begin
    posted = '0;
    posted[B_ABP] = stb.postAbp;
    posted[B_PDC] = stb.postPdc;
    posted[B_CC]  = stb.ctlWr;
  end

  assign ctlNext   = stb.ctlWr ? ((ctlQ & ~stb.ctlBitEn) | (stb.ctlData & stb.ctlBitEn)) : ctlQ;
  assign evtNext   = ((evtQ & ~stb.stsClr) | posted) & EVT_MASK;
  assign presNext  = stb.presClr ? 1'b0 : (stb.presSet ? 1'b1 : presQ);
  assign ilockNext = ilockQ ^ stb.ilockToggle;
  assign pendNext  = ctlNext[B_HPIE] & (|(evtNext & ctlNext & EVT_MASK));
  assign evtRise   = |(posted & ~evtQ);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ   <= CTL_RESET;
      evtQ   <= '0;
      presQ  <= presentAtReset;
      ilockQ <= 1'b0;
    end else begin
      ctlQ   <= ctlNext;
      evtQ   <= evtNext;
      presQ  <= presNext;
      ilockQ <= ilockNext;
    end
  end

  always_comb begin
    stsView = evtQ;
    stsView[B_PRES]  = presQ;
    stsView[B_ILOCK] = ilockQ;
  end

  assign rdData     = rdSel ? stsView : ctlQ;
  assign ilockState = ilockQ;

  // R4: a command always leaves the completion flag set
  p_cmd_done_r4: assert property (@(posedge clk) disable iff (!rstN)
    stb.ctlWr |=> evtQ[B_CC]);

  // R5: an interlock command flips the engaged state
  p_ilock_flip_r5: assert property (@(posedge clk) disable iff (!rstN)
    stb.ilockToggle |=> (ilockQ != $past(ilockQ)));

  // R6: presence cannot move while the interlock is engaged
  p_pres_frozen_r6: assert property (@(posedge clk) disable iff (!rstN)
    ilockQ |=> $stable(presQ));
endmodule

// File: rtl/slot_hotplug_ctl.sv
module slot_hotplug_ctl
  import slot_hp_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             presentAtReset,
  input  logic             wrEn,
  input  logic             wrSel,
  input  logic [1:0]       wrBe,
  input  logic [REG_W-1:0] wrData,
  input  logic             rdSel,
  output logic [REG_W-1:0] rdData,
  input  logic             addReq,
  input  logic             removeReq,
  output logic             reqBusy,
  input  logic             buttonPress,
  input  logic             msixEnable,
  input  logic             msiEnable,
  input  logic [VEC_W-1:0] vecNum,
  output logic             msgReq,
  output logic [VEC_W-1:0] msgVec,
  output logic             intxOut
);
  strobe_t stb;
  logic ilockState, pendNext, evtRise;

  slot_hp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrBe(wrBe), .wrData(wrData),
    .addReq(addReq), .removeReq(removeReq), .buttonPress(buttonPress),
    .ilockState(ilockState), .pendNext(pendNext), .evtRise(evtRise),
    .msixEnable(msixEnable), .msiEnable(msiEnable), .vecNum(vecNum),
    .stb(stb), .reqBusy(reqBusy), .msgReq(msgReq), .msgVec(msgVec), .intxOut(intxOut)
  );

  slot_hp_regs u_regs (
    .clk(clk), .rstN(rstN), .presentAtReset(presentAtReset), .stb(stb),
    .rdSel(rdSel), .rdData(rdData), .ilockState(ilockState),
    .pendNext(pendNext), .evtRise(evtRise)
  );
endmodule

// File: tb/slot_hotplug_ctl_test.sv
`timescale 1ns/1ps
module slot_hotplug_ctl_test;
  logic clk = 1'b0;
  logic rstN, presentAtReset, wrEn, wrSel, rdSel, addReq, removeReq, buttonPress;
  logic msixEnable, msiEnable, reqBusy, msgReq, intxOut;
  logic [1:0] wrBe;
  logic [15:0] wrData, rdData;
  logic [4:0] vecNum, msgVec;
  int nChecks = 0, nFails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  slot_hotplug_ctl uut (
    .clk(clk), .rstN(rstN), .presentAtReset(presentAtReset), .wrEn(wrEn), .wrSel(wrSel),
    .wrBe(wrBe), .wrData(wrData), .rdSel(rdSel), .rdData(rdData), .addReq(addReq),
    .removeReq(removeReq), .reqBusy(reqBusy), .buttonPress(buttonPress),
    .msixEnable(msixEnable), .msiEnable(msiEnable), .vecNum(vecNum),
    .msgReq(msgReq), .msgVec(msgVec), .intxOut(intxOut)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic sel, input logic [1:0] be, input logic [15:0] d);
    wrEn = 1'b1; wrSel = sel; wrBe = be; wrData = d;
    tick();
    wrEn = 1'b0; wrBe = 2'b00; wrData = '0;
  endtask

  task automatic rdChk(input string req, input logic sel, input logic [15:0] exp);
    rdSel = sel; #1;
    chk(req, rdData, exp);
  endtask

  task automatic press();
    buttonPress = 1'b1; tick(); buttonPress = 1'b0;
  endtask

  task automatic tReset();
    rdChk("R1 ctl reset", 1'b0, 16'h03C0);
    rdChk("R2 sts reset presence", 1'b1, 16'h0040);
    chk("R1 intx reset", {15'b0, intxOut}, 16'h0);
    chk("R1 msg reset", {15'b0, msgReq}, 16'h0);
  endtask

  task automatic tIntxAttn();
    wr(1'b0, 2'b11, 16'h03E1);
    rdChk("R4 cc posted", 1'b1, 16'h0050);
    chk("R9 no pending w/o cc enable", {15'b0, intxOut}, 16'h0);
    wr(1'b1, 2'b01, 16'h0010);
    rdChk("R8 cc w1c", 1'b1, 16'h0040);
    press();
    rdChk("R8 button flag", 1'b1, 16'h0041);
    chk("R11 intx raised", {15'b0, intxOut}, 16'h1);
    wr(1'b1, 2'b01, 16'h0001);
    chk("R11 intx dropped by sts write", {15'b0, intxOut}, 16'h0);
    rdChk("R8 button w1c", 1'b1, 16'h0040);
  endtask

  task automatic tMaskedEvent();
    msiEnable = 1'b1;
    wr(1'b0, 2'b11, 16'h03C1);
    wr(1'b1, 2'b01, 16'h0010);
    press();
    chk("R12 no msg while disabled", {15'b0, msgReq}, 16'h0);
    wr(1'b0, 2'b11, 16'h03E1);
    chk("R12 msg on enable", {15'b0, msgReq}, 16'h1);
    chk("R10 vector", {11'b0, msgVec}, 16'd9);
    tick();
    chk("R10 one cycle pulse", {15'b0, msgReq}, 16'h0);
    press();
    chk("R10 repost no msg", {15'b0, msgReq}, 16'h0);
    wr(1'b1, 2'b01, 16'h0011);
    chk("R11 sts drop silent", {15'b0, msgReq}, 16'h0);
    chk("R11 intx idle in msg mode", {15'b0, intxOut}, 16'h0);
    msiEnable = 1'b0;
  endtask

  task automatic tCmdDone();
    msixEnable = 1'b1;
    wr(1'b0, 2'b11, 16'h03F0);
    chk("R4 cc msg", {15'b0, msgReq}, 16'h1);
    wr(1'b0, 2'b11, 16'h03F0);
    chk("R10 no msg cc already set", {15'b0, msgReq}, 16'h0);
    wr(1'b0, 2'b11, 16'h03C0);
    chk("R10 msg on fall by ctl", {15'b0, msgReq}, 16'h1);
    wr(1'b1, 2'b01, 16'h0010);
    msixEnable = 1'b0;
  endtask

  task automatic tInterlock();
    wr(1'b0, 2'b10, 16'h0BC0);
    rdChk("R5 cmd bit reads 0", 1'b0, 16'h03C0);
    rdChk("R5 interlock engaged", 1'b1, 16'h00D0);
    addReq = 1'b1; #1;
    chk("R6 busy on add", {15'b0, reqBusy}, 16'h1);
    tick(); addReq = 1'b0;
    rdChk("R6 add refused", 1'b1, 16'h00D0);
    removeReq = 1'b1; #1;
    chk("R6 busy on remove", {15'b0, reqBusy}, 16'h1);
    tick(); removeReq = 1'b0;
    rdChk("R6 remove refused", 1'b1, 16'h00D0);
    wr(1'b0, 2'b10, 16'h0BC0);
    rdChk("R5 interlock released", 1'b1, 16'h0050);
    wr(1'b1, 2'b01, 16'h0010);
  endtask

  task automatic tHotSwap();
    wr(1'b0, 2'b11, 16'h03E8);
    wr(1'b1, 2'b01, 16'h0010);
    removeReq = 1'b1; #1;
    chk("R6 no busy when free", {15'b0, reqBusy}, 16'h0);
    tick(); removeReq = 1'b0;
    rdChk("R7 remove", 1'b1, 16'h0008);
    chk("R9 pdc pending", {15'b0, intxOut}, 16'h1);
    wr(1'b1, 2'b01, 16'h0008);
    chk("R11 intx cleared", {15'b0, intxOut}, 16'h0);
    addReq = 1'b1; tick(); addReq = 1'b0;
    rdChk("R7 add", 1'b1, 16'h0048);
    chk("R9 pdc pending again", {15'b0, intxOut}, 16'h1);
    wr(1'b1, 2'b01, 16'h0008);
    rdChk("R8 pdc w1c", 1'b1, 16'h0040);
  endtask

  task automatic tByteEn();
    wr(1'b0, 2'b01, 16'hFFFF);
    rdChk("R3 low byte only", 1'b0, 16'h03F9);
    rdChk("R5 no toggle w/o high byte", 1'b1, 16'h0050);
    chk("R9 cc pending", {15'b0, intxOut}, 16'h1);
    wr(1'b1, 2'b01, 16'h0010);
    chk("R11 cleared", {15'b0, intxOut}, 16'h0);
    wr(1'b0, 2'b00, 16'hFFFF);
    rdChk("R4 no command w/o enables", 1'b1, 16'h0040);
    wr(1'b1, 2'b11, 16'hFFC6);
    rdChk("R8 ro status ignored", 1'b1, 16'h0040);
    wr(1'b0, 2'b10, 16'h00FF);
    rdChk("R3 high byte write", 1'b0, 16'h00F9);
  endtask

  task automatic tReset2();
    wr(1'b0, 2'b10, 16'h0800);
    rdChk("R5 engaged before reset", 1'b1, 16'h00D0);
    presentAtReset = 1'b0;
    rstN = 1'b0; tick(); rstN = 1'b1;
    rdChk("R1 ctl after reset", 1'b0, 16'h03C0);
    rdChk("R2 sts after reset absent", 1'b1, 16'h0000);
    chk("R1 intx after reset", {15'b0, intxOut}, 16'h0);
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    rstN = 1'b0; presentAtReset = 1'b1; wrEn = 1'b0; wrSel = 1'b0; wrBe = 2'b00;
    wrData = '0; rdSel = 1'b0; addReq = 1'b0; removeReq = 1'b0; buttonPress = 1'b0;
    msixEnable = 1'b0; msiEnable = 1'b0; vecNum = 5'd9;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tReset();
    tIntxAttn();
    tMaskedEvent();
    tCmdDone();
    tInterlock();
    tHotSwap();
    tByteEn();
    tReset2();
    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule